// File: doc/BRIEF.md
# Instruction Breakpoint Address Comparator

This block watches the instruction fetch stream and raises a one-cycle hit when a fetched instruction falls on a programmed breakpoint. The breakpoint holds an enable, a word address, a 4-bit halfword-select mask and an optional link to a context comparator. Its configuration is written through a simple write strobe. Every fetch is compared against the configuration that was stored before that fetch's cycle.

The compare is not a plain address-equality test. For the fixed 32-bit instruction set, a word match counts only for the full mask or for the upper-halfword mask, and the latter only when the fetch qualifier flag is low. For the mixed 16/32-bit instruction set, each halfword of the word has its own select pair. A 32-bit instruction whose first halfword is unselected but whose second halfword is selected raises a hit only when the qualifier flag is low. The condition-pass state of the fetched instruction never changes the outcome.

A link that names a comparator which does not exist, or one that cannot match context, suppresses the event. A valid link additionally requires the named context comparator to be matching. The hit is registered and gated by a global debug enable.

Top module: `bp_match_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `bp_hit_o` is 0.
- R2: `bp_hit_o` is high in the cycle after a fetch with `fetch_valid_i`=1 and `dbg_en_i`=1 that matches. It is 0 in the cycle after any cycle where either of those inputs is 0.
- R3: With the enable clear, or with mask `cfg_bas_i`=4'b0000, no fetch ever produces a hit.
- R4: Fixed set (`fetch_mixed_i`=0): a hit needs fetch address bits [ADDR_W-1:2] equal to the stored word. Address bits [1:0] are ignored. Mask 4'b1111 hits. Mask 4'b1100 hits only when `fetch_lflag_i`=0. Every other mask gives no hit.
- R5: Mixed set (`fetch_mixed_i`=1): mask bits [1:0] select the halfword at word offset 0, and bits [3:2] select offset 2. A pair counts as selected when either of its bits is 1. An instruction whose first halfword is selected always hits, for example a 16- or 32-bit instruction at word+2 with mask 4'b1111.
- R6: Mixed set: a 32-bit instruction (`fetch_wide_i`=1) whose first halfword is unselected but whose second halfword is selected hits only when `fetch_lflag_i`=0. This includes a second halfword that lies in the following word.
- R7: With the link enabled, a link index of NUM_BP or more, or below NUM_BP-NUM_CTX (a comparator that is not context-aware), produces no hit.
- R8: With a valid link enabled, a hit also needs `ctx_match_i[index]`=1.
- R9: A configuration write is used only by fetches in later cycles. A fetch in the same cycle as the write is compared against the old configuration.
- R10: `fetch_cond_pass_i` has no effect on `bp_hit_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dbg_en_i | input | 1 | Global debug enable gating the hit |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_enable_i | input | 1 | Breakpoint enable value to store |
| cfg_word_i | input | ADDR_W-2 | Word address (address bits [ADDR_W-1:2]) to store |
| cfg_bas_i | input | 4 | Halfword-select mask to store |
| cfg_link_en_i | input | 1 | Link enable to store |
| cfg_link_idx_i | input | LINK_W | Linked comparator index to store |
| ctx_match_i | input | NUM_BP | Per-comparator context match states |
| fetch_valid_i | input | 1 | Fetch address valid this cycle |
| fetch_addr_i | input | ADDR_W | Instruction fetch byte address |
| fetch_mixed_i | input | 1 | 1: mixed 16/32-bit set, 0: fixed 32-bit set |
| fetch_wide_i | input | 1 | Mixed set: instruction is 32 bits |
| fetch_lflag_i | input | 1 | Qualifier flag for the ambiguous halfword cases |
| fetch_cond_pass_i | input | 1 | Condition-pass state of the instruction (no effect) |
| bp_hit_o | output | 1 | Registered breakpoint hit |

## Verification
The bench builds the block with ADDR_W=12, NUM_BP=6, NUM_CTX=2 and LINK_W=3. The narrow address makes the word wrap at the top of the address space reachable, so the next-word compare used by straddling instructions is exercised at its boundary. Random fetches land on or near the programmed word often enough to cover every mask value. With a 3-bit link index, values 6 and 7 name comparators that do not exist, and 0 to 3 name comparators that cannot match context, so both kinds of invalid link occur next to the valid indices 4 and 5.

// File: rtl/bp_match_pkg.sv
package bp_match_pkg;

  typedef enum logic {
    ISA_FIXED = 1'b0,
    ISA_MIXED = 1'b1
  } isa_e;

  localparam int unsigned LANES   = 2;
  localparam int unsigned SEL_W   = 2 * LANES;

  localparam logic [SEL_W-1:0] SEL_NONE  = 4'b0000;
  localparam logic [SEL_W-1:0] SEL_FULL  = 4'b1111;
  localparam logic [SEL_W-1:0] SEL_UPPER = 4'b1100;

endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/bp_cfg_regs.sv
module bp_cfg_regs
  import bp_match_pkg::*;
#(
  parameter int unsigned WA_W   = 30,
  parameter int unsigned LINK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              enable_i,
  input  logic [WA_W-1:0]   word_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              link_en_i,
  input  logic [LINK_W-1:0] link_idx_i,
  output logic              enable_q,
  output logic [WA_W-1:0]   word_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic              link_en_q,
  output logic [LINK_W-1:0] link_idx_q
);

  logic              enable_d;
  logic [WA_W-1:0]   word_d;
  logic [SEL_W-1:0]  sel_d;
  logic              link_en_d;
  logic [LINK_W-1:0] link_idx_d;

  always_comb begin
    enable_d   = enable_q;
    word_d     = word_q;
    sel_d      = sel_q;
    link_en_d  = link_en_q;
    link_idx_d = link_idx_q;
    if (we_i) begin
      enable_d   = enable_i;
      word_d     = word_i;
      sel_d      = sel_i;
      link_en_d  = link_en_i;
      link_idx_d = link_idx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q   <= 1'b0;
      word_q     <= '0;
      sel_q      <= SEL_NONE;
      link_en_q  <= 1'b0;
      link_idx_q <= '0;
    end else if (we_i) begin
      enable_q   <= enable_d;
      word_q     <= word_d;
      sel_q      <= sel_d;
      link_en_q  <= link_en_d;
      link_idx_q <= link_idx_d;
    end
  end

endmodule

// File: rtl/bp_addr_cmp.sv
module bp_addr_cmp
  import bp_match_pkg::*;
#(
  parameter int unsigned WA_W = 30
) (
  input  logic [WA_W-1:0]  cfg_word_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic [WA_W-1:0]  fetch_word_i,
  input  logic             fetch_half_i,
  input  isa_e             isa_i,
  input  logic             wide_i,
  input  logic             lflag_i,
  output logic             match_o
);

  logic [LANES-1:0] lane_on;
  logic [WA_W-1:0]  next_word;
  logic             word_eq;
  logic             next_eq;
  logic             head_hit;
  logic             tail_hit;
  logic             mixed_hit;
  logic             fixed_hit;

  // One select flag per halfword lane of the programmed word.
  for (genvar h = 0; h < LANES; h++) begin : g_lane
    assign lane_on[h] = |cfg_sel_i[2*h +: 2];
  end

  always_comb begin
    next_word = fetch_word_i + WA_W'(1);
    word_eq   = (fetch_word_i == cfg_word_i);
    next_eq   = (next_word == cfg_word_i);

    // First halfword of the instruction lies in a selected lane.
    head_hit = word_eq & lane_on[fetch_half_i];

    // Second halfword of a 32-bit instruction lies in a selected lane.
    tail_hit = 1'b0;
    if (wide_i) begin
      if (fetch_half_i) begin
        tail_hit = next_eq & lane_on[0];
      end else begin
        tail_hit = word_eq & lane_on[1];
      end
    end

    mixed_hit = head_hit | (tail_hit & ~lflag_i);
    fixed_hit = word_eq & ((cfg_sel_i == SEL_FULL) |
                           ((cfg_sel_i == SEL_UPPER) & ~lflag_i));

    match_o = (isa_i == ISA_MIXED) ? mixed_hit : fixed_hit;
  end

endmodule

// File: rtl/bp_link_chk.sv
module bp_link_chk #(
  parameter int unsigned NUM_BP  = 6,
  parameter int unsigned NUM_CTX = 2,
  parameter int unsigned LINK_W  = 4
) (
  input  logic              link_en_i,
  input  logic [LINK_W-1:0] link_idx_i,
  input  logic [NUM_BP-1:0] ctx_match_i,
  output logic              link_bad_o,
  output logic              link_pass_o
);

  localparam int unsigned FIRST_CTX = NUM_BP - NUM_CTX;

  logic [NUM_BP-1:0] aware_hit;
  logic [NUM_BP-1:0] ctx_hit;

  // Only the top NUM_CTX comparators can match context; any other index,
  // including one past the last comparator, decodes to nothing.
  for (genvar i = 0; i < NUM_BP; i++) begin : g_idx
    if (i >= FIRST_CTX) begin : g_aware
      assign aware_hit[i] = (link_idx_i == LINK_W'(i));
      assign ctx_hit[i]   = aware_hit[i] & ctx_match_i[i];
    end else begin : g_plain
      logic unused_ctx;
      assign unused_ctx   = ctx_match_i[i];
      assign aware_hit[i] = 1'b0;
      assign ctx_hit[i]   = 1'b0;
    end
  end

  always_comb begin
    link_bad_o  = link_en_i & ~(|aware_hit);
    link_pass_o = ~link_en_i | (|ctx_hit);
  end

endmodule

// File: rtl/bp_match_unit.sv
module bp_match_unit
  import bp_match_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NUM_BP  = 6,
  parameter int unsigned NUM_CTX = 2,
  parameter int unsigned LINK_W  = 4
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic              dbg_en_i,
  input  logic              cfg_we_i,
  input  logic              cfg_enable_i,
  input  logic [ADDR_W-3:0] cfg_word_i,
  input  logic [3:0]        cfg_bas_i,
  input  logic              cfg_link_en_i,
  input  logic [LINK_W-1:0] cfg_link_idx_i,
  input  logic [NUM_BP-1:0] ctx_match_i,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              fetch_mixed_i,
  input  logic              fetch_wide_i,
  input  logic              fetch_lflag_i,
  input  logic              fetch_cond_pass_i,
  output logic              bp_hit_o
);

  localparam int unsigned WA_W = ADDR_W - 2;

  logic              rst_n;
  logic              enable_q;
  logic [WA_W-1:0]   word_q;
  logic [SEL_W-1:0]  sel_q;
  logic              link_en_q;
  logic [LINK_W-1:0] link_idx_q;
  logic              addr_match;
  logic              link_bad;
  logic              link_pass;
  logic              armed;
  logic              hit_d;
  logic              hit_q;
  isa_e              isa;
  logic              unused_bits;

  // Byte offset bit and condition state never take part in the compare.
  assign unused_bits = ^{fetch_addr_i[0], fetch_cond_pass_i};
  assign isa         = fetch_mixed_i ? ISA_MIXED : ISA_FIXED;

  bp_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_n)
  );

  bp_cfg_regs #(
    .WA_W   (WA_W),
    .LINK_W (LINK_W)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .we_i       (cfg_we_i),
    .enable_i   (cfg_enable_i),
    .word_i     (cfg_word_i),
    .sel_i      (cfg_bas_i),
    .link_en_i  (cfg_link_en_i),
    .link_idx_i (cfg_link_idx_i),
    .enable_q   (enable_q),
    .word_q     (word_q),
    .sel_q      (sel_q),
    .link_en_q  (link_en_q),
    .link_idx_q (link_idx_q)
  );

  bp_addr_cmp #(
    .WA_W (WA_W)
  ) u_cmp (
    .cfg_word_i   (word_q),
    .cfg_sel_i    (sel_q),
    .fetch_word_i (fetch_addr_i[ADDR_W-1:2]),
    .fetch_half_i (fetch_addr_i[1]),
    .isa_i        (isa),
    .wide_i       (fetch_wide_i),
    .lflag_i      (fetch_lflag_i),
    .match_o      (addr_match)
  );

  bp_link_chk #(
    .NUM_BP  (NUM_BP),
    .NUM_CTX (NUM_CTX),
    .LINK_W  (LINK_W)
  ) u_link (
    .link_en_i   (link_en_q),
    .link_idx_i  (link_idx_q),
    .ctx_match_i (ctx_match_i),
    .link_bad_o  (link_bad),
    .link_pass_o (link_pass)
  );

  always_comb begin
    // An all-zero mask behaves exactly like a cleared enable.
    armed = enable_q & (sel_q != SEL_NONE);
    hit_d = fetch_valid_i & dbg_en_i & armed & addr_match & link_pass & ~link_bad;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
    end
  end

  assign bp_hit_o = hit_q;

endmodule

// File: rtl/bp_match_unit_chk.sv
module bp_match_unit_chk #(
  parameter int unsigned SEL_BITS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                dbg_en_i,
  input logic                fetch_valid_i,
  input logic                fetch_mixed_i,
  input logic                enable_q,
  input logic [SEL_BITS-1:0] sel_q,
  input logic                link_bad,
  input logic                bp_hit_o
);

  // R2: no hit follows a cycle without a valid fetch
  p_no_fetch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> !bp_hit_o);

  // R2: no hit follows a cycle with debug disabled
  p_dbg_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_en_i |=> !bp_hit_o);

  // R3: cleared enable or empty mask never hits
  p_disarmed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_q || sel_q == '0) |=> !bp_hit_o);

  // R4: fixed set only hits with the full or upper mask
  p_fixed_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_mixed_i && sel_q != 4'b1111 && sel_q != 4'b1100) |=> !bp_hit_o);

  // R7: an invalid link suppresses the event
  p_bad_link_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_bad |=> !bp_hit_o);

endmodule

bind bp_match_unit bp_match_unit_chk #(.SEL_BITS(4)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_n),
  .dbg_en_i      (dbg_en_i),
  .fetch_valid_i (fetch_valid_i),
  .fetch_mixed_i (fetch_mixed_i),
  .enable_q      (enable_q),
  .sel_q         (sel_q),
  .link_bad      (link_bad),
  .bp_hit_o      (bp_hit_o)
);

// File: tb/bp_match_unit_test.sv
`timescale 1ns/1ps
module bp_match_unit_test;

  localparam int ADDR_W  = 12;
  localparam int NUM_BP  = 6;
  localparam int NUM_CTX = 2;
  localparam int LINK_W  = 3;
  localparam int MASK    = (1 << ADDR_W) - 1;

  logic              clk = 1'b0;
  logic              arst_n;
  logic              dbg_en;
  logic              cfg_we;
  logic              cfg_enable;
  logic [ADDR_W-3:0] cfg_word;
  logic [3:0]        cfg_bas;
  logic              cfg_link_en;
  logic [LINK_W-1:0] cfg_link_idx;
  logic [NUM_BP-1:0] ctx_match;
  logic              fetch_valid;
  logic [ADDR_W-1:0] fetch_addr;
  logic              fetch_mixed;
  logic              fetch_wide;
  logic              fetch_lflag;
  logic              fetch_cond;
  logic              bp_hit;

  always #2.5 clk = ~clk;

  bp_match_unit #(
    .ADDR_W(ADDR_W), .NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX), .LINK_W(LINK_W)
  ) uut (
    .clk_i(clk), .arst_ni(arst_n), .dbg_en_i(dbg_en),
    .cfg_we_i(cfg_we), .cfg_enable_i(cfg_enable), .cfg_word_i(cfg_word),
    .cfg_bas_i(cfg_bas), .cfg_link_en_i(cfg_link_en), .cfg_link_idx_i(cfg_link_idx),
    .ctx_match_i(ctx_match), .fetch_valid_i(fetch_valid), .fetch_addr_i(fetch_addr),
    .fetch_mixed_i(fetch_mixed), .fetch_wide_i(fetch_wide), .fetch_lflag_i(fetch_lflag),
    .fetch_cond_pass_i(fetch_cond), .bp_hit_o(bp_hit)
  );

  // Reference model state
  bit m_en, m_link_en;
  int m_word, m_idx;
  bit [3:0] m_bas;
  bit exp_hit;
  string prev_req;
  int n_checks, n_fail;
  bit finished;

  // Next-cycle stimulus
  bit n_dbg, n_we, n_en, n_len, n_valid, n_mixed, n_wide, n_lflag, n_cond;
  int n_word, n_idx, n_addr;
  bit [3:0] n_bas;
  bit [NUM_BP-1:0] n_ctx;

  function automatic bit in_sel(int ha);
    int base;
    base = m_word * 4;
    if (ha == base && (m_bas[0] || m_bas[1])) return 1'b1;
    if (ha == base + 2 && (m_bas[2] || m_bas[3])) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit model(bit v, bit dbg, int a, bit mixed, bit wide,
                               bit lflag, bit [NUM_BP-1:0] ctx);
    int first, second;
    if (!v || !dbg || !m_en || m_bas == 4'b0000) return 1'b0;
    if (m_link_en) begin
      if (m_idx >= NUM_BP || m_idx < NUM_BP - NUM_CTX) return 1'b0;
      if (!ctx[m_idx]) return 1'b0;
    end
    if (!mixed) begin
      if ((a & ~3) != m_word * 4) return 1'b0;
      if (m_bas == 4'b1111) return 1'b1;
      if (m_bas == 4'b1100) return !lflag;
      return 1'b0;
    end
    first  = a & ~1;
    second = (first + 2) & MASK;
    if (in_sel(first)) return 1'b1;
    if (wide && in_sel(second)) return !lflag;
    return 1'b0;
  endfunction

  task automatic tick(input string req);
    @(negedge clk);
    if (!finished) begin
      n_checks++;
      if (bp_hit !== exp_hit) begin
        n_fail++;
        $display("FAIL %s: bp_hit_o actual=%0b expected=%0b at %0t",
                 prev_req, bp_hit, exp_hit, $time);
      end
    end
    dbg_en = n_dbg; cfg_we = n_we; cfg_enable = n_en;
    cfg_word = n_word[ADDR_W-3:0]; cfg_bas = n_bas;
    cfg_link_en = n_len; cfg_link_idx = n_idx[LINK_W-1:0];
    ctx_match = n_ctx; fetch_valid = n_valid; fetch_addr = n_addr[ADDR_W-1:0];
    fetch_mixed = n_mixed; fetch_wide = n_wide; fetch_lflag = n_lflag;
    fetch_cond = n_cond;
    exp_hit = model(n_valid, n_dbg, n_addr, n_mixed, n_wide, n_lflag, n_ctx);
    if (n_we) begin
      m_en = n_en; m_word = n_word; m_bas = n_bas;
      m_link_en = n_len; m_idx = n_idx;
    end
    prev_req = req;
  endtask

  task automatic wcfg(bit en, int word, bit [3:0] bas, bit len, int idx);
    n_we = 1; n_en = en; n_word = word; n_bas = bas; n_len = len; n_idx = idx;
    n_valid = 0;
    tick("R9");
    n_we = 0;
  endtask

  task automatic fetch(int a, bit mixed, bit wide, bit lflag, input string req);
    n_valid = 1; n_addr = a; n_mixed = mixed; n_wide = wide; n_lflag = lflag;
    tick(req);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; finished = 0; exp_hit = 0; prev_req = "R1";
    m_en = 0; m_link_en = 0; m_word = 0; m_idx = 0; m_bas = 0;
    n_dbg = 1; n_we = 0; n_en = 0; n_len = 0; n_valid = 0; n_mixed = 0;
    n_wide = 0; n_lflag = 0; n_cond = 1; n_word = 0; n_idx = 0; n_addr = 0;
    n_bas = 0; n_ctx = '1;
    dbg_en = 1; cfg_we = 0; cfg_enable = 0; cfg_word = 0; cfg_bas = 0;
    cfg_link_en = 0; cfg_link_idx = 0; ctx_match = '1; fetch_valid = 0;
    fetch_addr = 0; fetch_mixed = 0; fetch_wide = 0; fetch_lflag = 0; fetch_cond = 1;
    arst_n = 0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (bp_hit !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: bp_hit_o actual=%0b expected=0 during reset", bp_hit);
    end
    arst_n = 1;
    repeat (4) tick("R1");

    // R4: fixed set
    wcfg(1, 'h40, 4'b1111, 0, 0);
    fetch('h100, 0, 0, 0, "R4");
    fetch('h104, 0, 0, 0, "R4");
    fetch('h102, 0, 0, 1, "R4");
    wcfg(1, 'h40, 4'b1100, 0, 0);
    fetch('h100, 0, 0, 0, "R4");
    fetch('h100, 0, 0, 1, "R4");
    wcfg(1, 'h40, 4'b0011, 0, 0);
    fetch('h100, 0, 0, 0, "R4");

    // R3: disabled and empty mask
    wcfg(1, 'h40, 4'b0000, 0, 0);
    fetch('h100, 1, 0, 0, "R3");
    fetch('h100, 0, 0, 0, "R3");
    wcfg(0, 'h40, 4'b1111, 0, 0);
    fetch('h100, 1, 0, 0, "R3");
    fetch('h100, 0, 0, 0, "R3");

    // R5: mixed set head matches
    wcfg(1, 'h40, 4'b0011, 0, 0);
    fetch('h100, 1, 0, 0, "R5");
    fetch('h102, 1, 0, 0, "R5");
    wcfg(1, 'h40, 4'b1100, 0, 0);
    fetch('h102, 1, 0, 1, "R5");
    fetch('h100, 1, 0, 0, "R5");
    wcfg(1, 'h40, 4'b1111, 0, 0);
    fetch('h102, 1, 0, 1, "R5");
    fetch('h102, 1, 1, 1, "R5");

    // R6: tail-only matches
    wcfg(1, 'h40, 4'b1100, 0, 0);
    fetch('h100, 1, 1, 0, "R6");
    fetch('h100, 1, 1, 1, "R6");
    wcfg(1, 'h40, 4'b0011, 0, 0);
    fetch('h0FE, 1, 1, 0, "R6");
    fetch('h0FE, 1, 1, 1, "R6");
    fetch('h0FE, 1, 0, 0, "R6");
    wcfg(1, 0, 4'b0001, 0, 0);
    fetch('hFFE, 1, 1, 0, "R6");

    // R2: gating
    wcfg(1, 'h40, 4'b1111, 0, 0);
    n_dbg = 0; fetch('h100, 0, 0, 0, "R2");
    n_dbg = 1; fetch('h100, 0, 0, 0, "R2");
    n_valid = 0; tick("R2");

    // R10: condition state ignored
    n_cond = 0; fetch('h100, 0, 0, 0, "R10");
    fetch('h102, 1, 0, 0, "R10");
    n_cond = 1;

    // R7 and R8: links
    n_ctx = '1;
    wcfg(1, 'h40, 4'b1111, 1, 7);
    fetch('h100, 0, 0, 0, "R7");
    wcfg(1, 'h40, 4'b1111, 1, 6);
    fetch('h100, 0, 0, 0, "R7");
    wcfg(1, 'h40, 4'b1111, 1, 1);
    fetch('h100, 0, 0, 0, "R7");
    wcfg(1, 'h40, 4'b1111, 1, 5);
    fetch('h100, 0, 0, 0, "R8");
    n_ctx = 6'b011111; fetch('h100, 0, 0, 0, "R8");
    n_ctx = 6'b010000;
    wcfg(1, 'h40, 4'b1111, 1, 4);
    fetch('h100, 0, 0, 0, "R8");
    n_ctx = '1;

    // R9: write and fetch in the same cycle use the old setting
    wcfg(1, 'h40, 4'b1111, 0, 0);
    n_we = 1; n_en = 0; n_valid = 1; n_addr = 'h100; n_mixed = 0;
    tick("R9");
    n_we = 0; tick("R9");
    n_we = 1; n_en = 1; n_word = 'h41; tick("R9");
    n_we = 0; n_addr = 'h104; tick("R9");

    // Mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      n_we = ($urandom_range(0, 15) == 0);
      n_en = ($urandom_range(0, 7) != 0);
      n_word = $urandom_range(0, (1 << (ADDR_W - 2)) - 1);
      if ($urandom_range(0, 3) == 0) n_word = (1 << (ADDR_W - 2)) - 1;
      n_bas = 4'($urandom_range(0, 15));
      n_len = ($urandom_range(0, 3) == 0);
      n_idx = $urandom_range(0, 7);
      n_ctx = NUM_BP'($urandom_range(0, 63));
      n_dbg = ($urandom_range(0, 9) != 0);
      n_valid = ($urandom_range(0, 5) != 0);
      n_addr = (m_word * 4 + $urandom_range(0, 15) - 6) & MASK & ~1;
      n_mixed = $urandom_range(0, 1);
      n_wide = $urandom_range(0, 1);
      n_lflag = $urandom_range(0, 1);
      n_cond = $urandom_range(0, 1);
      tick("R4 R5 R6 R7 R8 R9 R10 random");
    end
    n_we = 0; n_valid = 0;
    tick("R2");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule